// File: doc/BRIEF.md
# Serial Audio Frame Lock and Rate Monitor

This block sits beside the bit-level decoder of a two-channel serial digital audio receiver and runs on a fast reference clock. It receives a one-cycle strobe at the start of each decoded frame and another for each preamble error. From the spacing of the frame strobes it decides whether the incoming stream is stable enough to call locked. Once locked it holds a measured interval count from which software obtains the sample rate: rate = f_ref / (32 × count) with the default prescale.

Alongside lock it reports three conditions: no signal (no frames at all), bad format (the frame spacing jumped while locked) and low frequency (the interval is too long to measure). It pulses event lines when lock is gained, when lock is lost and on every preamble error. An optional automatic mode drops lock and restarts acquisition after a run of preamble errors. The reference clock must run faster than 768 times the sample rate, and the supported sample rates span 8 kHz to 192 kHz. Clearing the receive enable returns every output to its idle value.

Top module: `spdif_lock_monitor`

## Requirements
- R1: While reset is applied, and after reset with no frame yet, the status word reads 0x0000_0001 (bit 0 = 1 means unlocked) and the event word reads 0.
- R2: Lock is declared when LOCK_RUN consecutive frame intervals each lie within one eighth (integer divide) of the previous interval. Status bit 0 then reads 0, and event bit 1 pulses for exactly one cycle. Both changes appear two clock edges after the strobe that completes the run.
- R3: Status bits 16 upward (IFS_W bits) hold the locked interval count, equal to the strobe spacing in reference cycles shifted right by DIV_LOG2. These bits read 0 whenever bit 0 is 1.
- R4: An interval that differs from the previous one by more than one eighth of that previous interval restarts the run at one and does not produce lock.
- R5: While locked, an interval that differs from the latched count by more than one eighth of it, or that saturates, causes unlock. Bad-format status bit 1 is set and stays set until the next lock or until disable, and loss event bit 2 pulses for one cycle.
- R6: When the shifted interval reaches 2^IFS_W − 1 it saturates there, and low-frequency status bit 2 is set. The bit clears at the next measurement that is not saturated.
- R7: When no frame strobe arrives for NOSIG_CYCLES reference cycles, no-signal status bit 3 and bit 0 are set, and event bit 2 pulses if the block was locked. The next strobe clears bit 3.
- R8: Each preamble-error strobe seen while enabled pulses event bit 13 in the following cycle.
- R9: With auto_unlock high, PRE_ERR_LIMIT preamble errors with no error-free frame strobe between them force unlock, without setting bad format, and pulse event bit 2. An error-free frame strobe restarts this count.
- R10: With auto_unlock low, preamble errors leave the lock state and the count unchanged.
- R11: While rx_enable is low, strobes are ignored. One edge after rx_enable falls, the status word reads 0x0000_0001 and the event word reads 0, and no event fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_enable | input | 1 | Receiver enable; low clears and idles the block |
| auto_unlock | input | 1 | Enables the forced unlock after repeated preamble errors |
| frame_stb | input | 1 | One-cycle strobe at each frame start |
| preamble_err | input | 1 | One-cycle strobe for each preamble error |
| status_o | output | 32 | Status: bit0 unlocked, bit1 bad format, bit2 low frequency, bit3 no signal, bits 16+ interval count |
| event_o | output | 15 | Event pulses: bit1 locked, bit2 loss, bit13 preamble error |

## Verification
The bench builds the block with IFS_W = 6, DIV_LOG2 = 2, NOSIG_CYCLES = 400 and PRE_ERR_LIMIT = 3, and keeps LOCK_RUN = 4. A divide-by-4 prescale with a 6-bit count makes the count saturate for intervals of 252 cycles or more. A 400-cycle silence limit makes the no-signal timeout, the low-frequency flag and the preamble-error threshold reachable within a few thousand cycles. With the default 12-bit, divide-by-32 build, the same corners would need more than 130,000 cycles per frame.

// File: rtl/spdlk_pkg.sv
// Package: bit positions of the status and event words shared by the
// monitor, its sub-blocks and its checker.
package spdlk_pkg;
    localparam int STATUS_W   = 32;
    localparam int EVENT_W    = 15;
    localparam int ST_UNLOCK  = 0;
    localparam int ST_BADFMT  = 1;
    localparam int ST_LOWFREQ = 2;
    localparam int ST_QUIET   = 3;
    localparam int ST_CNT_LSB = 16;
    localparam int ST_CNT_MAX = 12;
    localparam int EV_LOCKED  = 1;
    localparam int EV_LOSS    = 2;
    localparam int EV_PREERR  = 13;
endpackage

// File: rtl/spdlk_interval_timer.sv
// Interval timer: counts reference cycles between frame strobes, emits a
// prescaled, saturated interval one cycle after each strobe, and raises a
// silence timeout when no strobe arrives for NOSIG_CYCLES cycles.
// Assumes: frame_stb is a single-cycle pulse; NOSIG_CYCLES exceeds the
// saturation interval so that low frequency stays reachable.
module spdlk_interval_timer #(
    parameter int IFS_W        = 12,
    parameter int DIV_LOG2     = 5,
    parameter int NOSIG_CYCLES = 262144
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             frame_stb_i,
    output logic             meas_vld_o,
    output logic [IFS_W-1:0] meas_o,
    output logic             timeout_o,
    output logic             quiet_o
);
    localparam int EW = $clog2(NOSIG_CYCLES + 1);
    localparam int FW = EW + 1;
    localparam logic [FW-1:0] MAX_TICKS = FW'(2 ** IFS_W - 1);
    localparam logic [EW-1:0] LAST_CYC  = EW'(NOSIG_CYCLES - 1);

    logic [EW-1:0]    elapsed_q;
    logic             have_ref_q;
    logic             quiet_q;
    logic             vld_q;
    logic             timeout_q;
    logic [IFS_W-1:0] meas_q;
    logic [FW-1:0]    span;
    logic [FW-1:0]    ticks;
    logic [IFS_W-1:0] ticks_sat;

    // Prescale the current span and clamp it at the field maximum.
    always_comb begin
        span      = {1'b0, elapsed_q} + FW'(1);
        ticks     = span >> DIV_LOG2;
        ticks_sat = (ticks >= MAX_TICKS) ? MAX_TICKS[IFS_W-1:0] : ticks[IFS_W-1:0];
    end

    // Track cycles since the last strobe and publish measurements/timeouts.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            elapsed_q  <= '0;
            have_ref_q <= 1'b0;
            quiet_q    <= 1'b0;
            vld_q      <= 1'b0;
            timeout_q  <= 1'b0;
            meas_q     <= '0;
        end else begin
            vld_q     <= 1'b0;
            timeout_q <= 1'b0;
            if (frame_stb_i) begin
                elapsed_q  <= '0;
                quiet_q    <= 1'b0;
                have_ref_q <= 1'b1;
                if (have_ref_q) begin
                    vld_q  <= 1'b1;
                    meas_q <= ticks_sat;
                end
            end else if (!quiet_q) begin
                if (elapsed_q == LAST_CYC) begin
                    quiet_q    <= 1'b1;
                    timeout_q  <= 1'b1;
                    have_ref_q <= 1'b0;
                end else begin
                    elapsed_q <= elapsed_q + EW'(1);
                end
            end
        end
    end

    assign meas_vld_o = vld_q;
    assign meas_o     = meas_q;
    assign timeout_o  = timeout_q;
    assign quiet_o    = quiet_q;
endmodule

// File: rtl/spdlk_preamble_guard.sv
// Preamble guard: pulses an event per preamble error and, when automatic
// unlock is on, requests a forced unlock after PRE_ERR_LIMIT errors with
// no error-free frame strobe between them.
// Assumes: PRE_ERR_LIMIT >= 1; strobes are single-cycle pulses.
module spdlk_preamble_guard #(
    parameter int PRE_ERR_LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic auto_i,
    input  logic frame_stb_i,
    input  logic pre_err_i,
    output logic pre_evt_o,
    output logic force_o
);
    localparam int CW = $clog2(PRE_ERR_LIMIT + 1);
    localparam logic [CW-1:0] LAST_ERR = CW'(PRE_ERR_LIMIT - 1);

    logic [CW-1:0] run_q;
    logic          evt_q;
    logic          force_q;

    // Count consecutive preamble errors and issue the forced-unlock pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            run_q   <= '0;
            evt_q   <= 1'b0;
            force_q <= 1'b0;
        end else begin
            evt_q   <= pre_err_i;
            force_q <= 1'b0;
            if (pre_err_i) begin
                if (run_q == LAST_ERR) begin
                    if (auto_i) begin
                        force_q <= 1'b1;
                        run_q   <= '0;
                    end
                end else begin
                    run_q <= run_q + CW'(1);
                end
            end else if (frame_stb_i) begin
                run_q <= '0;
            end
        end
    end

    assign pre_evt_o = evt_q;
    assign force_o   = force_q;
endmodule

// File: rtl/spdlk_lock_tracker.sv
// Lock tracker: builds a run of mutually close intervals, declares lock
// after LOCK_RUN of them, latches the count, and drops lock on a jump,
// saturation, silence timeout or forced unlock.
// Assumes: LOCK_RUN >= 2; at most one of timeout/force/meas per cycle
// matters, and timeout/force take priority over a measurement.
module spdlk_lock_tracker #(
    parameter int IFS_W    = 12,
    parameter int LOCK_RUN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             meas_vld_i,
    input  logic [IFS_W-1:0] meas_i,
    input  logic             timeout_i,
    input  logic             force_i,
    output logic             locked_o,
    output logic             badfmt_o,
    output logic             lowfreq_o,
    output logic [IFS_W-1:0] count_o,
    output logic             evt_locked_o,
    output logic             evt_loss_o
);
    localparam int RW = $clog2(LOCK_RUN + 1);

    logic             locked_q;
    logic             badfmt_q;
    logic             lowfreq_q;
    logic [IFS_W-1:0] count_q;
    logic [IFS_W-1:0] prev_q;
    logic             prev_vld_q;
    logic [RW-1:0]    run_q;
    logic             evt_locked_q;
    logic             evt_loss_q;
    logic             sat;
    logic             close_prev;
    logic             close_lock;
    logic [RW-1:0]    run_nxt;

    // True when value lies within one eighth of base.
    function automatic logic near(input logic [IFS_W-1:0] value,
                                  input logic [IFS_W-1:0] base);
        logic [IFS_W-1:0] diff;
        diff = (value > base) ? (value - base) : (base - value);
        return diff <= (base >> 3);
    endfunction

    // Classify the incoming measurement against history and latched count.
    always_comb begin
        sat        = &meas_i;
        close_prev = prev_vld_q && near(meas_i, prev_q);
        close_lock = near(meas_i, count_q);
        run_nxt    = close_prev ? (run_q + RW'(1)) : RW'(1);
    end

    // Lock state machine with flags and one-cycle event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            locked_q     <= 1'b0;
            badfmt_q     <= 1'b0;
            lowfreq_q    <= 1'b0;
            count_q      <= '0;
            prev_q       <= '0;
            prev_vld_q   <= 1'b0;
            run_q        <= '0;
            evt_locked_q <= 1'b0;
            evt_loss_q   <= 1'b0;
        end else begin
            evt_locked_q <= 1'b0;
            evt_loss_q   <= 1'b0;
            if (timeout_i || force_i) begin
                if (locked_q) begin
                    evt_loss_q <= 1'b1;
                end
                locked_q   <= 1'b0;
                count_q    <= '0;
                run_q      <= '0;
                prev_vld_q <= 1'b0;
            end else if (meas_vld_i) begin
                lowfreq_q <= sat;
                if (locked_q) begin
                    if (sat || !close_lock) begin
                        locked_q   <= 1'b0;
                        count_q    <= '0;
                        badfmt_q   <= 1'b1;
                        evt_loss_q <= 1'b1;
                        prev_q     <= meas_i;
                        prev_vld_q <= !sat;
                        run_q      <= sat ? RW'(0) : RW'(1);
                    end
                end else if (sat) begin
                    run_q      <= '0;
                    prev_vld_q <= 1'b0;
                end else begin
                    prev_q     <= meas_i;
                    prev_vld_q <= 1'b1;
                    if (run_nxt == RW'(LOCK_RUN)) begin
                        locked_q     <= 1'b1;
                        count_q      <= meas_i;
                        badfmt_q     <= 1'b0;
                        evt_locked_q <= 1'b1;
                        run_q        <= '0;
                    end else begin
                        run_q <= run_nxt;
                    end
                end
            end
        end
    end

    assign locked_o     = locked_q;
    assign badfmt_o     = badfmt_q;
    assign lowfreq_o    = lowfreq_q;
    assign count_o      = count_q;
    assign evt_locked_o = evt_locked_q;
    assign evt_loss_o   = evt_loss_q;
endmodule

// File: rtl/spdif_lock_monitor.sv
// Top: frame-timing lock and rate monitor on a reference clock. Combines
// the interval timer, lock tracker and preamble guard and packs their
// results into the status and event words.
// Assumes: IFS_W <= 12; strobes come from the bit decoder already
// synchronous to clk.
module spdif_lock_monitor
    import spdlk_pkg::*;
#(
    parameter int IFS_W         = 12,
    parameter int DIV_LOG2      = 5,
    parameter int LOCK_RUN      = 4,
    parameter int NOSIG_CYCLES  = 262144,
    parameter int PRE_ERR_LIMIT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_enable,
    input  logic                auto_unlock,
    input  logic                frame_stb,
    input  logic                preamble_err,
    output logic [STATUS_W-1:0] status_o,
    output logic [EVENT_W-1:0]  event_o
);
    logic             meas_vld;
    logic [IFS_W-1:0] meas;
    logic             timeout;
    logic             quiet;
    logic             pre_evt;
    logic             force_unlock;
    logic             locked;
    logic             badfmt;
    logic             lowfreq;
    logic [IFS_W-1:0] count;
    logic             evt_locked;
    logic             evt_loss;

    spdlk_interval_timer #(
        .IFS_W(IFS_W), .DIV_LOG2(DIV_LOG2), .NOSIG_CYCLES(NOSIG_CYCLES)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .enable_i(rx_enable), .frame_stb_i(frame_stb),
        .meas_vld_o(meas_vld), .meas_o(meas), .timeout_o(timeout), .quiet_o(quiet)
    );

    spdlk_preamble_guard #(
        .PRE_ERR_LIMIT(PRE_ERR_LIMIT)
    ) u_guard (
        .clk(clk), .rst_n(rst_n), .enable_i(rx_enable), .auto_i(auto_unlock),
        .frame_stb_i(frame_stb), .pre_err_i(preamble_err),
        .pre_evt_o(pre_evt), .force_o(force_unlock)
    );

    spdlk_lock_tracker #(
        .IFS_W(IFS_W), .LOCK_RUN(LOCK_RUN)
    ) u_tracker (
        .clk(clk), .rst_n(rst_n), .enable_i(rx_enable),
        .meas_vld_i(meas_vld), .meas_i(meas), .timeout_i(timeout), .force_i(force_unlock),
        .locked_o(locked), .badfmt_o(badfmt), .lowfreq_o(lowfreq), .count_o(count),
        .evt_locked_o(evt_locked), .evt_loss_o(evt_loss)
    );

    // Pack flags and the interval field into the status word.
    always_comb begin
        status_o             = '0;
        status_o[ST_UNLOCK]  = ~locked;
        status_o[ST_BADFMT]  = badfmt;
        status_o[ST_LOWFREQ] = lowfreq;
        status_o[ST_QUIET]   = quiet;
        for (int i = 0; i < IFS_W; i++) begin
            status_o[ST_CNT_LSB + i] = count[i];
        end
    end

    // Pack the event pulses into the event word.
    always_comb begin
        event_o            = '0;
        event_o[EV_LOCKED] = evt_locked;
        event_o[EV_LOSS]   = evt_loss;
        event_o[EV_PREERR] = pre_evt;
    end
endmodule

// File: rtl/spdlk_checker.sv
// Checker: temporal properties of the monitor's ports, bound to the top.
module spdlk_checker
    import spdlk_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                rx_enable,
    input logic                preamble_err,
    input logic [STATUS_W-1:0] status_o,
    input logic [EVENT_W-1:0]  event_o
);
    // R3: count field is cleared whenever unlocked
    p_count_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[ST_UNLOCK] |-> (status_o[ST_CNT_LSB +: ST_CNT_MAX] == '0));

    // R2: locked event is a single-cycle pulse
    p_locked_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        event_o[EV_LOCKED] |=> !event_o[EV_LOCKED]);

    // R2: locked event coincides with the locked state
    p_locked_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        event_o[EV_LOCKED] |-> !status_o[ST_UNLOCK]);

    // R5: loss event coincides with the unlocked state
    p_loss_unlocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        event_o[EV_LOSS] |-> status_o[ST_UNLOCK]);

    // R5: bad format only shows while unlocked
    p_badfmt_unlocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[ST_BADFMT] |-> status_o[ST_UNLOCK]);

    // R8: every enabled preamble error pulses its event next cycle
    p_preerr_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && preamble_err) |=> event_o[EV_PREERR]);

    // R11: disable returns the outputs to idle one edge later
    p_disable_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> (status_o == 32'h1 && event_o == '0));
endmodule

bind spdif_lock_monitor spdlk_checker u_spdlk_checker (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .preamble_err(preamble_err),
    .status_o(status_o), .event_o(event_o)
);

// File: tb/test_spdif_lock_monitor.sv
module test_spdif_lock_monitor;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_enable = 1'b0;
    logic        auto_unlock = 1'b0;
    logic        frame_stb = 1'b0;
    logic        preamble_err = 1'b0;
    logic [31:0] status_o;
    logic [14:0] event_o;

    int compared = 0;
    int mismatched = 0;
    int loss_seen = 0;
    bit finished = 0;
    logic [31:0] st;
    logic [14:0] ev;
    logic [14:0] ev_first;

    // {gap between strobes, expected status, expected events}
    localparam logic [63:0] VEC [12] = '{
        {16'd80,  32'h0000_0001, 16'h0000},
        {16'd80,  32'h0000_0001, 16'h0000},
        {16'd120, 32'h0000_0001, 16'h0000},
        {16'd80,  32'h0000_0001, 16'h0000},
        {16'd80,  32'h0000_0001, 16'h0000},
        {16'd84,  32'h0000_0001, 16'h0000},
        {16'd80,  32'h0014_0000, 16'h0002},
        {16'd88,  32'h0014_0000, 16'h0000},
        {16'd100, 32'h0000_0003, 16'h0004},
        {16'd100, 32'h0000_0003, 16'h0000},
        {16'd100, 32'h0000_0003, 16'h0000},
        {16'd100, 32'h0019_0000, 16'h0002}
    };

    spdif_lock_monitor #(
        .IFS_W(6), .DIV_LOG2(2), .LOCK_RUN(4), .NOSIG_CYCLES(400), .PRE_ERR_LIMIT(3)
    ) i_spdif_lock_monitor (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .auto_unlock(auto_unlock),
        .frame_stb(frame_stb), .preamble_err(preamble_err),
        .status_o(status_o), .event_o(event_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) if (event_o[2]) loss_seen++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Strobe a frame 'gap' cycles after the previous one, sample 2 edges later.
    task automatic frame_after(input int gap);
        repeat (gap - 2) @(negedge clk);
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        @(negedge clk);
        st = status_o;
        ev = event_o;
    endtask

    // One preamble error; ev_first one cycle later, st/ev two cycles later.
    task automatic pre_error();
        preamble_err = 1'b1;
        @(negedge clk);
        preamble_err = 1'b0;
        ev_first = event_o;
        @(negedge clk);
        st = status_o;
        ev = event_o;
    endtask

    task automatic restart();
        rx_enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rx_enable = 1'b1;
    endtask

    task automatic lock_at(input int gap);
        frame_after(2);
        for (int k = 0; k < 4; k++) frame_after(gap);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int losses;
        repeat (3) @(negedge clk);
        check("R1 status in reset", status_o, 32'h1);
        check("R1 events in reset", {17'b0, event_o}, 32'h0);
        rst_n = 1'b1;
        rx_enable = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 status idle", status_o, 32'h1);

        // Table: R2 lock, R3 count, R4 run restart, R5 bad format
        frame_after(2);
        for (int i = 0; i < 12; i++) begin
            frame_after(int'(VEC[i][63:48]));
            check($sformatf("R2/R3/R4/R5 vector %0d status", i), st, VEC[i][47:16]);
            check($sformatf("R2/R5 vector %0d events", i), {17'b0, ev}, {16'b0, VEC[i][15:0]});
        end

        // R8 and R10: errors with automatic unlock off
        for (int k = 0; k < 4; k++) begin
            pre_error();
            check("R8 preamble event", {17'b0, ev_first}, 32'h2000);
            check("R8 preamble event ends", {17'b0, ev}, 32'h0);
        end
        check("R10 lock kept", st, 32'h0019_0000);

        // R11: disable clears and ignores strobes
        losses = loss_seen;
        rx_enable = 1'b0;
        @(negedge clk);
        check("R11 disable status", status_o, 32'h1);
        for (int k = 0; k < 5; k++) frame_after(80);
        check("R11 strobes ignored", st, 32'h1);
        check("R11 no events", {17'b0, ev}, 32'h0);
        check("R11 no loss event", loss_seen, losses);

        // R9: forced unlock after repeated errors
        rx_enable = 1'b1;
        auto_unlock = 1'b1;
        lock_at(80);
        check("R9 locked first", st, 32'h0014_0000);
        pre_error();
        pre_error();
        frame_after(76);
        check("R9 clean frame keeps lock", st, 32'h0014_0000);
        pre_error();
        pre_error();
        check("R9 count restarted after clean frame", st, 32'h0014_0000);
        pre_error();
        check("R9 forced unlock status", st, 32'h1);
        check("R9 forced loss event", {17'b0, ev}, 32'h4);
        auto_unlock = 1'b0;

        // R7: silence timeout
        restart();
        lock_at(80);
        check("R7 locked before silence", st, 32'h0014_0000);
        losses = loss_seen;
        repeat (420) @(negedge clk);
        check("R7 no-signal status", status_o, 32'h9);
        check("R7 loss event on silence", loss_seen, losses + 1);
        frame_after(2);
        check("R7 strobe clears no-signal", st, 32'h1);

        // R6: saturated interval
        restart();
        frame_after(2);
        frame_after(300);
        check("R6 low frequency set", st, 32'h5);
        frame_after(80);
        check("R6 low frequency cleared", st, 32'h1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule